// File: doc/BRIEF.md
# Two-Flip-Flop JK Mealy Machine

This block is a four-state synchronous machine with one serial input bit and one output bit. Its memory is a pair of JK flip-flops, a high bit and a low bit. The J and K inputs of both flip-flops are fixed Boolean functions of the present state and the input. Each flip-flop moves to its next value on the rising clock edge by the JK rule: hold on JK=00, set on 10, clear on 01, toggle on 11. The output is a Mealy output. It is high only when both state bits are high and the input is high in the same cycle.

The excitation terms are as follows:
- High bit: J = (not x) and lo, K = x or lo.
- Low bit: J = x or hi, K = not x.

These terms give one fixed transition graph. The states are named by their {hi,lo} code: S0=00, S1=01, S2=10, S3=11. The transitions are:
- T_S0_HOLD: S0 with x=0 stays in S0.
- T_S1_ADV: S1 with x=0 goes to S2.
- T_S2_ADV: S2 with x=0 goes to S3.
- T_S3_WRAP: S3 with x=0 goes to S0.
- T_ANY_JUMP: x=1 from any of the four states goes to S1. From S3 this transition also raises z.

A synchronous active-high reset returns the machine to S0. Both state bits are brought out to ports so the state can be observed.

Top module: `dual_jk_mealy`

## Requirements
- R1: When rst is high at a rising edge, the state {q_hi,q_lo} becomes 00 (S0) after that edge.
- R2: When rst is low and x_in=1 at a rising edge, the state becomes 01 (S1) after that edge, whatever the present state.
- R3: From state 00 with x_in=0 at a rising edge, the state stays 00.
- R4: From state 01 with x_in=0 at a rising edge, the state becomes 10.
- R5: From state 10 with x_in=0 at a rising edge, the state becomes 11.
- R6: From state 11 with x_in=0 at a rising edge, the state becomes 00.
- R7: z_out is 1 exactly when q_hi=1, q_lo=1 and x_in=1 in the same cycle. It follows x_in with no register delay.
- R8: The state depends only on x_in at the rising edge. Pulses on x_in between edges have no effect on the next state.
- R9: Reset takes priority over the input. With rst=1 and x_in=1 at an edge, the next state is 00, not 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Serial input bit, sampled each rising edge |
| z_out | output | 1 | Mealy output (state 11 and x_in=1) |
| q_hi | output | 1 | High state bit |
| q_lo | output | 1 | Low state bit |

## Verification
Only z_out is due within the cycle its inputs appear, because it is combinational. The bench therefore reads z_out a short settle time after it drives x_in at the falling edge, before the next rising edge. The state bits change one register stage after the rising edge that samples x_in. So every state check reads q_hi and q_lo one time unit after that edge, never on it. The glitch test pulses x_in and returns it to its final value inside the low phase. The check then waits one edge and compares against the value that was stable at the edge.

// File: rtl/dual_jk_pkg.sv
package dual_jk_pkg;

    localparam int STATE_W = 2;
    localparam int HI_IDX  = 1;
    localparam int LO_IDX  = 0;

    typedef enum logic [STATE_W-1:0] {
        ST_S0 = 2'b00,
        ST_S1 = 2'b01,
        ST_S2 = 2'b10,
        ST_S3 = 2'b11
    } jk_state_e;

    typedef struct packed {
        logic j;
        logic k;
    } jk_drive_t;

endpackage

// File: rtl/jk_excite.sv
module jk_excite
    import dual_jk_pkg::*;
(
    input  logic [STATE_W-1:0] cur_q,
    input  logic               x_bit,
    output jk_drive_t          drive [STATE_W]
);

    logic hi;
    logic lo;

    always_comb begin
        hi = cur_q[HI_IDX];
        lo = cur_q[LO_IDX];
        // high flip-flop: set only when x low and low bit set; clear on x or low bit
        drive[HI_IDX].j = ~x_bit & lo;
        drive[HI_IDX].k = x_bit | lo;
        // low flip-flop: set on x or high bit; clear whenever x low
        drive[LO_IDX].j = x_bit | hi;
        drive[LO_IDX].k = ~x_bit;
    end

endmodule

// File: rtl/jk_cell.sv
module jk_cell #(
    parameter logic INIT_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic j,
    input  logic k,
    output logic q
);

    logic q_next;

    // behavioural characteristic equation: hold / set / clear / toggle
    always_comb begin
        q_next = (~k & q) | (j & ~q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= INIT_VAL;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/dual_jk_mealy.sv
module dual_jk_mealy
    import dual_jk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x_in,
    output logic z_out,
    output logic q_hi,
    output logic q_lo
);

    logic [STATE_W-1:0] state_bits;
    jk_drive_t          drive [STATE_W];
    jk_state_e          cur_state;

    jk_excite u_excite (
        .cur_q (state_bits),
        .x_bit (x_in),
        .drive (drive)
    );

    // state register: one JK cell per state bit
    for (genvar g = 0; g < STATE_W; g++) begin : g_ff
        jk_cell #(
            .INIT_VAL (1'b0)
        ) u_cell (
            .clk (clk),
            .rst (rst),
            .j   (drive[g].j),
            .k   (drive[g].k),
            .q   (state_bits[g])
        );
    end

    always_comb begin
        cur_state = jk_state_e'(state_bits);
    end

    // output process: Mealy output decoded per named state
    always_comb begin
        unique case (cur_state)
            ST_S0:   z_out = 1'b0;
            ST_S1:   z_out = 1'b0;
            ST_S2:   z_out = 1'b0;
            ST_S3:   z_out = x_in;
            default: z_out = 1'b0;
        endcase
    end

    assign q_hi = state_bits[HI_IDX];
    assign q_lo = state_bits[LO_IDX];

endmodule

// File: rtl/dual_jk_mealy_chk.sv
module dual_jk_mealy_chk (
    input logic clk,
    input logic rst,
    input logic x_in,
    input logic z_out,
    input logic q_hi,
    input logic q_lo
);

    p_reset_to_s0_r1: assert property (@(posedge clk)
        rst |=> (!q_hi && !q_lo));

    p_x_jumps_s1_r2: assert property (@(posedge clk) disable iff (rst)
        x_in |=> (!q_hi && q_lo));

    p_s0_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!x_in && !q_hi && !q_lo) |=> (!q_hi && !q_lo));

    p_s1_adv_r4: assert property (@(posedge clk) disable iff (rst)
        (!x_in && !q_hi && q_lo) |=> (q_hi && !q_lo));

    p_s2_adv_r5: assert property (@(posedge clk) disable iff (rst)
        (!x_in && q_hi && !q_lo) |=> (q_hi && q_lo));

    p_s3_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (!x_in && q_hi && q_lo) |=> (!q_hi && !q_lo));

    p_z_needs_all_r7: assert property (@(posedge clk) disable iff (rst)
        z_out |-> (q_hi && q_lo && x_in));

    p_z_fires_r7: assert property (@(posedge clk) disable iff (rst)
        (q_hi && q_lo && x_in) |-> z_out);

endmodule

bind dual_jk_mealy dual_jk_mealy_chk chk_i (
    .clk   (clk),
    .rst   (rst),
    .x_in  (x_in),
    .z_out (z_out),
    .q_hi  (q_hi),
    .q_lo  (q_lo)
);

// File: tb/dual_jk_mealy_tb_top.sv
`timescale 1ns/1ps
module dual_jk_mealy_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_in = 1'b0;
    logic z_out;
    logic q_hi;
    logic q_lo;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    dual_jk_mealy dut_i (
        .clk   (clk),
        .rst   (rst),
        .x_in  (x_in),
        .z_out (z_out),
        .q_hi  (q_hi),
        .q_lo  (q_lo)
    );

    // vector: {present[1:0], x, next[1:0], z}
    localparam logic [5:0] VEC [8] = '{
        {2'b00, 1'b0, 2'b00, 1'b0},
        {2'b00, 1'b1, 2'b01, 1'b0},
        {2'b01, 1'b0, 2'b10, 1'b0},
        {2'b01, 1'b1, 2'b01, 1'b0},
        {2'b10, 1'b0, 2'b11, 1'b0},
        {2'b10, 1'b1, 2'b01, 1'b0},
        {2'b11, 1'b0, 2'b00, 1'b0},
        {2'b11, 1'b1, 2'b01, 1'b1}
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_next(input logic [1:0] s, input logic x);
        if (x) return 2'b01;
        case (s)
            2'b00:   return 2'b00;
            2'b01:   return 2'b10;
            2'b10:   return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] s, input logic x);
        if (x) return "R2";
        case (s)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    // drive at falling edge, clock once, land 1 ns after rising edge
    task automatic step(input logic x);
        @(negedge clk);
        x_in = x;
        @(posedge clk);
        #1;
    endtask

    task automatic goto_state(input logic [1:0] s);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        if (s != 2'b00) step(1'b1);
        if (s[1]) step(1'b0);
        if (s == 2'b11) step(1'b0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset", {q_hi, q_lo}, 2'b00);
        check("R7 z in reset state", {1'b0, z_out}, 2'b00);

        // exhaustive table walk
        for (int i = 0; i < 8; i++) begin
            logic [1:0] ps;
            logic       xv;
            logic [1:0] ns;
            logic       zv;
            {ps, xv, ns, zv} = VEC[i];
            goto_state(ps);
            check("table present", {q_hi, q_lo}, ps);
            @(negedge clk);
            x_in = xv;
            #0.5;
            check("R7 z", {1'b0, z_out}, {1'b0, zv});
            @(posedge clk);
            #1;
            check(req_of(ps, xv), {q_hi, q_lo}, ns);
        end

        // R8: glitch on x between edges; stable 0 at edge from S2 -> S3
        goto_state(2'b10);
        @(negedge clk);
        x_in = 1'b0;
        #0.3 x_in = 1'b1;
        #0.5 x_in = 1'b0;
        #0.3 x_in = 1'b1;
        #0.3 x_in = 1'b0;
        @(posedge clk);
        #1;
        check("R8 glitch ignored", {q_hi, q_lo}, 2'b11);

        // R9: reset wins over x=1
        goto_state(2'b10);
        @(negedge clk);
        rst = 1'b1;
        x_in = 1'b1;
        @(posedge clk);
        #1;
        check("R9 reset priority", {q_hi, q_lo}, 2'b00);
        @(negedge clk);
        rst = 1'b0;
        x_in = 1'b0;

        // random sequence against table reference
        goto_state(2'b00);
        for (int c = 0; c < 300; c++) begin
            logic [1:0] s_now;
            logic       xr;
            s_now = {q_hi, q_lo};
            xr = 1'($urandom_range(0, 1));
            @(negedge clk);
            x_in = xr;
            #0.5;
            check("R7 random z", {1'b0, z_out}, {1'b0, s_now[1] & s_now[0] & xr});
            @(posedge clk);
            #1;
            check(req_of(s_now, xr), {q_hi, q_lo}, ref_next(s_now, xr));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule